// File: doc/BRIEF.md
# SDRAM Power-Up and Command Sequencer

This block sits on the controller side of a four-bank single-data-rate SDRAM and owns its command pins: chip select, the three strobes that encode a command, the two bank-select bits, the address bus and the byte masks. Once reset is released it brings the memory up by itself. It idles with NOPs while holding every mask line high. It then closes all banks, runs a fixed number of auto-refresh cycles and writes the mode register. After that it raises `init_done`.

Once initialised, it takes single commands from a client through a valid/ready handshake. Each request carries a code, a bank, a row or column, and an auto-precharge flag. Every bank has its own state: off, idle, open or precharging. Each bank also has its own down-counters for the row-to-column delay, the minimum open time and the precharge time. Shared counters cover the refresh recovery time and the mode-register recovery time.

A request is accepted only in a cycle where the target bank can legally take it. Every accepted request appears on the pins on the next clock edge. A periodic timer forces refreshes: it blocks new requests, closes any open banks with a precharge-all and then issues an auto refresh. All delays are parameters counted in clock cycles.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is asserted, chip select is high, all mask lines are high, `init_done` is low and `req_ready` is low.
- R2: After reset is released, the first T_INIT edges drive NOP (chip select low, RAS#/CAS#/WE# = 1/1/1) with all mask lines high. Edge T_INIT+1 drives PRECHARGE (0/1/0) with address bit 10 high, which means all banks.
- R3: The initial precharge-all is followed by N_INIT_REF AUTO REFRESH commands (0/0/1). The first comes T_RP edges after the precharge, and each later one comes T_RFC edges after the previous one.
- R4: T_RFC edges after the last initial refresh, LOAD MODE (0/0/0) is driven with bank 0. Its address word has burst-length code in [2:0], burst type in [3], CAS-latency code in [6:4], zeros in [8:7], the single-location write flag in [9] and zeros above. On that same edge `init_done` rises and the mask lines go low.
- R5: Request codes are 0 ACTIVE (0/1/1), 1 READ (1/0/1), 2 WRITE (1/0/0), 3 PRECHARGE (0/1/0) and 4 REFRESH (0/0/1). Each accepted request appears on the next edge, with the bank driven as a binary index on the bank pins.
- R6: ACTIVE is accepted only for an idle bank and drives the row on the address bus. Banks are independent, so an ACTIVE to another idle bank may follow on the very next edge.
- R7: READ or WRITE to a bank is accepted no earlier than T_RCD edges after that bank's ACTIVE. The column is driven with bit 10 replaced by the auto-precharge flag. With that flag set, the request also waits until T_RAS edges after the ACTIVE and leaves the bank precharging.
- R8: A single-bank PRECHARGE (address bit 10 low) to an open bank is accepted no earlier than T_RAS edges after its ACTIVE.
- R9: After a precharge of a bank, whether explicit or automatic, a new ACTIVE to that bank is accepted T_RP edges later.
- R10: REFRESH is accepted only when all four banks are idle. No request is accepted for T_RFC edges after an AUTO REFRESH, or for T_MRD edges after LOAD MODE.
- R11: T_REFI edges after LOAD MODE, a refresh becomes pending and `req_ready` drops. Open banks are closed by a precharge-all on the next edge, AUTO REFRESH follows T_RP edges later, and held requests resume T_RFC edges after that.
- R12: Request codes 5 to 7 are accepted at once and drive NOP.
- R13: No command other than NOP is driven unless it comes from the power-up sequence, the refresh timer or an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_cmd | input | 3 | Request code |
| req_bank | input | 2 | Target bank |
| req_addr | input | ADDR_W | Row for ACTIVE, column for READ/WRITE |
| req_ap | input | 1 | Auto-precharge with READ/WRITE |
| init_done | output | 1 | Power-up sequence finished |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | ADDR_W | Address bus |
| sd_dqm | output | DQM_W | Byte mask lines |

## Verification
The assertions rely on the client keeping `req_bank`, `req_cmd`, `req_addr` and `req_ap` stable while `req_valid` is high and `req_ready` is low. They also rely on the timing parameters all being at least one cycle. The bench drives requests only through a task that holds every field until the acceptance edge and drops `req_valid` straight afterwards. It also steers clear of the refresh timer's window until the one test that aims at it, so no request is caught half-accepted.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int ADDR_W     = 12,
  parameter int DQM_W      = 4,
  parameter int T_INIT     = 20,
  parameter int T_RP       = 3,
  parameter int T_RCD      = 3,
  parameter int T_RAS      = 6,
  parameter int T_RFC      = 7,
  parameter int T_MRD      = 2,
  parameter int N_INIT_REF = 2,
  parameter int T_REFI     = 300,
  parameter logic [2:0] BL_CODE   = 3'b011,
  parameter bit         BURST_ILV = 1'b1,
  parameter logic [2:0] CL_CODE   = 3'b010,
  parameter bit         WB_SINGLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_cmd,
  input  logic [1:0]        req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_ap,
  output logic              init_done,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQM_W-1:0]  sd_dqm
);
  localparam int NB   = 4;
  localparam int BMAX = (T_RAS > T_RP) ? ((T_RAS > T_RCD) ? T_RAS : T_RCD)
                                       : ((T_RP > T_RCD) ? T_RP : T_RCD);
  localparam int GMAX = (T_INIT > T_RFC) ? ((T_INIT > T_MRD) ? T_INIT : T_MRD)
                                         : ((T_RFC > T_MRD) ? T_RFC : T_MRD);
  localparam int BW = $clog2(BMAX + 1);
  localparam int GW = $clog2(GMAX + 1);
  localparam int RW = $clog2(T_REFI + 1);
  localparam int NW = $clog2(N_INIT_REF + 1);
  localparam logic [ADDR_W-1:0] MODE_WORD =
    ADDR_W'({WB_SINGLE, 2'b00, CL_CODE, BURST_ILV, BL_CODE});

  localparam logic [2:0] CMD_NOP = 3'b111, CMD_ACT = 3'b011, CMD_RD  = 3'b101,
                         CMD_WR  = 3'b100, CMD_PRE = 3'b010, CMD_REF = 3'b001,
                         CMD_MRS = 3'b000;
  localparam logic [2:0] RQ_ACT = 3'd0, RQ_RD = 3'd1, RQ_WR = 3'd2,
                         RQ_PRE = 3'd3, RQ_REF = 3'd4;

  typedef enum logic [1:0] {B_OFF, B_IDLE, B_ACT, B_PRE} bank_t;
  typedef enum logic [1:0] {PH_WAIT, PH_IREF, PH_MRS, PH_RUN} phase_t;

  bank_t          bst   [NB];
  logic [BW-1:0]  bcnt  [NB];
  logic [BW-1:0]  rcd_q [NB];
  logic [BW-1:0]  ras_q [NB];
  logic [GW-1:0]  gcnt;
  logic [RW-1:0]  rcnt;
  logic [NW-1:0]  nref;
  logic           ref_pend;
  phase_t         ph;
  logic [2:0]     cmd_q;

  logic [NB-1:0]     b_idle, b_open, b_closable, b_ras_wait;
  logic              all_idle, req_ok, take, ref_fire, pall_fire;
  logic [ADDR_W-1:0] col_a;

  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      b_idle[b]     = (bst[b] == B_IDLE) || (bst[b] == B_PRE && bcnt[b] == '0);
      b_open[b]     = (bst[b] == B_ACT);
      b_ras_wait[b] = b_open[b] && (ras_q[b] != '0);
      b_closable[b] = (bst[b] != B_OFF) && !b_ras_wait[b];
    end
    col_a     = req_addr;
    col_a[10] = req_ap;
  end

  assign all_idle = (&b_idle) && (gcnt == '0);

  always_comb begin
    case (req_cmd)
      RQ_ACT:        req_ok = b_idle[req_bank];
      RQ_RD, RQ_WR:  req_ok = b_open[req_bank] && (rcd_q[req_bank] == '0) &&
                              (!req_ap || ras_q[req_bank] == '0);
      RQ_PRE:        req_ok = b_closable[req_bank];
      RQ_REF:        req_ok = &b_idle;
      default:       req_ok = 1'b1;
    endcase
  end

  assign req_ready = (ph == PH_RUN) && !ref_pend && (gcnt == '0) && req_ok;
  assign take      = req_valid && req_ready;
  assign ref_fire  = (ph == PH_RUN) && ref_pend && all_idle;
  assign pall_fire = (ph == PH_RUN) && ref_pend && (gcnt == '0) &&
                     (|b_open) && !(|b_ras_wait);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= CMD_NOP;
      sd_cs_n   <= 1'b1;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dqm    <= '1;
      ph        <= PH_WAIT;
      gcnt      <= GW'(T_INIT);
      nref      <= NW'(N_INIT_REF);
      rcnt      <= '0;
      ref_pend  <= 1'b0;
      init_done <= 1'b0;
      for (int b = 0; b < NB; b++) begin
        bst[b]   <= B_OFF;
        bcnt[b]  <= '0;
        rcd_q[b] <= '0;
        ras_q[b] <= '0;
      end
    end else begin
      sd_cs_n <= 1'b0;
      cmd_q   <= CMD_NOP;
      sd_ba   <= '0;
      sd_addr <= '0;
      if (gcnt != '0) gcnt <= gcnt - 1'b1;
      for (int b = 0; b < NB; b++) begin
        if (bcnt[b]  != '0) bcnt[b]  <= bcnt[b]  - 1'b1;
        if (rcd_q[b] != '0) rcd_q[b] <= rcd_q[b] - 1'b1;
        if (ras_q[b] != '0) ras_q[b] <= ras_q[b] - 1'b1;
        if (bst[b] == B_PRE && bcnt[b] == '0) bst[b] <= B_IDLE;
      end

      case (ph)
        PH_WAIT: if (gcnt == '0) begin
          cmd_q       <= CMD_PRE;
          sd_addr[10] <= 1'b1;
          ph          <= PH_IREF;
          for (int b = 0; b < NB; b++) begin
            bst[b]  <= B_PRE;
            bcnt[b] <= BW'(T_RP - 1);
          end
        end
        PH_IREF: if (all_idle) begin
          cmd_q <= CMD_REF;
          gcnt  <= GW'(T_RFC - 1);
          nref  <= nref - 1'b1;
          if (nref == NW'(1)) ph <= PH_MRS;
        end
        PH_MRS: if (all_idle) begin
          cmd_q     <= CMD_MRS;
          sd_addr   <= MODE_WORD;
          gcnt      <= GW'(T_MRD - 1);
          rcnt      <= RW'(T_REFI - 1);
          init_done <= 1'b1;
          sd_dqm    <= '0;
          ph        <= PH_RUN;
        end
        default: begin
          if (ref_fire) begin
            cmd_q    <= CMD_REF;
            gcnt     <= GW'(T_RFC - 1);
            ref_pend <= 1'b0;
          end else if (pall_fire) begin
            cmd_q       <= CMD_PRE;
            sd_addr[10] <= 1'b1;
            for (int b = 0; b < NB; b++) begin
              bst[b]  <= B_PRE;
              bcnt[b] <= BW'(T_RP - 1);
            end
          end else if (take) begin
            sd_ba <= req_bank;
            case (req_cmd)
              RQ_ACT: begin
                cmd_q           <= CMD_ACT;
                sd_addr         <= req_addr;
                bst[req_bank]   <= B_ACT;
                rcd_q[req_bank] <= BW'(T_RCD - 1);
                ras_q[req_bank] <= BW'(T_RAS - 1);
              end
              RQ_RD, RQ_WR: begin
                cmd_q   <= (req_cmd == RQ_RD) ? CMD_RD : CMD_WR;
                sd_addr <= col_a;
                if (req_ap) begin
                  bst[req_bank]  <= B_PRE;
                  bcnt[req_bank] <= BW'(T_RP - 1);
                end
              end
              RQ_PRE: begin
                cmd_q          <= CMD_PRE;
                bst[req_bank]  <= B_PRE;
                bcnt[req_bank] <= BW'(T_RP - 1);
              end
              RQ_REF: begin
                cmd_q <= CMD_REF;
                gcnt  <= GW'(T_RFC - 1);
              end
              default: sd_ba <= '0;
            endcase
          end
          if (rcnt == '0) begin
            ref_pend <= 1'b1;
            rcnt     <= RW'(T_REFI - 1);
          end else begin
            rcnt <= rcnt - 1'b1;
          end
        end
      endcase
    end
  end

  logic is_rw, is_pre, is_ref, is_mrs;
  assign is_rw  = !sd_cs_n && (cmd_q == CMD_RD || cmd_q == CMD_WR);
  assign is_pre = !sd_cs_n && (cmd_q == CMD_PRE);
  assign is_ref = !sd_cs_n && (cmd_q == CMD_REF);
  assign is_mrs = !sd_cs_n && (cmd_q == CMD_MRS);

  p_mask_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (sd_dqm == {DQM_W{1'b1}}));
  p_no_ready_early_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !req_ready);
  p_mode_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (sd_addr == MODE_WORD && $rose(init_done)));
  p_ref_all_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> $past(&b_idle && gcnt == '0));

  for (genvar g = 0; g < NB; g++) begin : g_bank_chk
    p_rcd_met_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rw && sd_ba == 2'(g)) |-> $past(bst[g] == B_ACT && rcd_q[g] == '0));
    p_ras_met_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pre && (sd_addr[10] || sd_ba == 2'(g))) |->
      $past(bst[g] != B_ACT || ras_q[g] == '0));
  end
endmodule

// File: tb/test_sdram_cmd_seq.sv
`timescale 1ns/1ps
module test_sdram_cmd_seq;
  localparam int AW = 12, DW = 4;
  localparam int T_INIT = 20, T_RP = 3, T_RCD = 3, T_RAS = 6, T_RFC = 7;
  localparam int T_MRD = 2, N_INIT_REF = 2, T_REFI = 300;
  localparam logic [2:0] BL = 3'b011, CL = 3'b010;
  localparam bit ILV = 1'b1, WBS = 1'b1;
  localparam logic [2:0] E_NOP = 3'b111, E_ACT = 3'b011, E_RD = 3'b101, E_WR = 3'b100,
                         E_PRE = 3'b010, E_REF = 3'b001, E_MRS = 3'b000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_ap = 1'b0, init_done;
  logic [2:0] req_cmd = '0;
  logic [1:0] req_bank = '0;
  logic [AW-1:0] req_addr = '0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba;
  logic [AW-1:0] sd_addr;
  logic [DW-1:0] sd_dqm;

  sdram_cmd_seq #(.ADDR_W(AW), .DQM_W(DW), .T_INIT(T_INIT), .T_RP(T_RP), .T_RCD(T_RCD),
    .T_RAS(T_RAS), .T_RFC(T_RFC), .T_MRD(T_MRD), .N_INIT_REF(N_INIT_REF), .T_REFI(T_REFI),
    .BL_CODE(BL), .BURST_ILV(ILV), .CL_CODE(CL), .WB_SINGLE(WBS)) i_sdram_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_bank(req_bank), .req_addr(req_addr), .req_ap(req_ap),
    .init_done(init_done), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  typedef struct packed {
    logic [2:0] c; logic [1:0] ba; logic [AW-1:0] a; logic [DW-1:0] dqm; logic [31:0] cy;
  } item_t;
  item_t exp_q[$];
  string tag_q[$];
  int n_chk = 0, n_fail = 0, unexp = 0, t_mrs = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_cmd(input logic [2:0] c, input logic [1:0] ba,
                            input logic [AW-1:0] a, input logic [DW-1:0] dqm,
                            input int cy, input string tag);
    item_t it;
    it.c = c; it.ba = ba; it.a = a; it.dqm = dqm; it.cy = cy;
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && !sd_cs_n && {sd_ras_n, sd_cas_n, sd_we_n} != E_NOP) begin
      if (exp_q.size() == 0) begin
        unexp++;
        check(1'b0, "R13", "unexpected command", {sd_ras_n, sd_cas_n, sd_we_n}, E_NOP);
      end else begin
        item_t it;
        string tg;
        it = exp_q.pop_front();
        tg = tag_q.pop_front();
        if (it.c == E_MRS) t_mrs = cyc;
        check({sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr, sd_dqm} ==
              {it.c, it.ba, it.a, it.dqm}, tg, "command/bank/addr/mask",
              {sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr, sd_dqm},
              {it.c, it.ba, it.a, it.dqm});
        check(cyc == int'(it.cy), tg, "issue cycle", cyc, it.cy);
      end
    end
  end

  task automatic send(input logic [2:0] rc, input logic [1:0] bank,
                      input logic [AW-1:0] a, input bit ap, input string tag,
                      output int acc);
    logic [2:0] ec;
    logic [AW-1:0] ea;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = rc; req_bank = bank; req_addr = a; req_ap = ap;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    acc = cyc + 1;
    ea = a;
    case (rc)
      3'd0: ec = E_ACT;
      3'd1: begin ec = E_RD; ea[10] = ap; end
      3'd2: begin ec = E_WR; ea[10] = ap; end
      3'd3: begin ec = E_PRE; ea = '0; end
      default: begin ec = E_REF; ea = '0; end
    endcase
    expect_cmd(ec, bank, ea, '0, acc, tag);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R13", "watchdog expired", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int pre_cy, m, a0, a1, r, w, x, p0, y, q, q1, f, g, h, k;
    logic [AW-1:0] mw;
    mw = AW'((int'(WBS) << 9) | (int'(CL) << 4) | (int'(ILV) << 3) | int'(BL));
    pre_cy = T_INIT + 1;
    m = pre_cy + T_RP + N_INIT_REF * T_RFC;
    expect_cmd(E_PRE, 2'd0, AW'(1 << 10), '1, pre_cy, "R2");
    for (int i = 0; i < N_INIT_REF; i++)
      expect_cmd(E_REF, 2'd0, '0, '1, pre_cy + T_RP + i * T_RFC, "R3");
    expect_cmd(E_MRS, 2'd0, mw, '0, m, "R4");

    repeat (3) @(negedge clk);
    check(sd_cs_n == 1'b1, "R1", "chip select in reset", sd_cs_n, 1);
    check(sd_dqm == '1, "R1", "masks in reset", sd_dqm, 4'hf);
    check(init_done == 1'b0, "R1", "init_done in reset", init_done, 0);
    check(req_ready == 1'b0, "R1", "ready in reset", req_ready, 0);
    rst_n = 1'b1;

    while (cyc != T_INIT / 2) @(negedge clk);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm} == {1'b0, E_NOP, 4'hf}, "R2",
          "NOP with masks high", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm},
          {1'b0, E_NOP, 4'hf});
    req_valid = 1'b1; req_cmd = 3'd0;
    #1 check(req_ready == 1'b0, "R13", "ready before init", req_ready, 0);
    req_valid = 1'b0;
    while (cyc < m) @(negedge clk);
    check(init_done == 1'b1, "R4", "init_done after mode load", init_done, 1);

    send(3'd0, 2'd0, 12'h123, 1'b0, "R6", a0);
    check(a0 == m + T_MRD, "R10", "first request after mode load", a0, m + T_MRD);
    send(3'd0, 2'd1, 12'h0ab, 1'b0, "R6", a1);
    check(a1 == a0 + 1, "R6", "ACTIVE to other bank next edge", a1, a0 + 1);
    send(3'd1, 2'd0, 12'h010, 1'b0, "R7", r);
    check(r == a0 + T_RCD, "R7", "READ after T_RCD", r, a0 + T_RCD);
    send(3'd2, 2'd1, 12'h020, 1'b1, "R7", w);
    check(w == a1 + T_RAS, "R7", "auto-precharge WRITE waits T_RAS", w, a1 + T_RAS);
    send(3'd0, 2'd1, 12'h0cd, 1'b0, "R9", x);
    check(x == w + T_RP, "R9", "ACTIVE after auto-precharge", x, w + T_RP);
    send(3'd3, 2'd0, 12'hfff, 1'b0, "R8", p0);
    check(p0 == x + 1, "R8", "PRECHARGE of long-open bank", p0, x + 1);
    send(3'd0, 2'd0, 12'h456, 1'b0, "R9", y);
    check(y == p0 + T_RP, "R9", "ACTIVE after PRECHARGE", y, p0 + T_RP);
    send(3'd3, 2'd0, 12'h000, 1'b0, "R8", q);
    check(q == y + T_RAS, "R8", "PRECHARGE waits T_RAS", q, y + T_RAS);
    send(3'd3, 2'd1, 12'h000, 1'b0, "R8", q1);
    check(q1 == q + 1, "R8", "second PRECHARGE", q1, q + 1);
    send(3'd4, 2'd0, 12'h000, 1'b0, "R10", f);
    check(f == q1 + T_RP, "R10", "REFRESH once all idle", f, q1 + T_RP);
    send(3'd0, 2'd2, 12'h3ff, 1'b0, "R5", g);
    check(g == f + T_RFC, "R10", "request after T_RFC", g, f + T_RFC);
    send(3'd0, 2'd3, 12'h800, 1'b0, "R5", h);
    check(h == g + 1, "R5", "bank 3 ACTIVE", h, g + 1);

    @(negedge clk);
    req_valid = 1'b1; req_cmd = 3'd7; req_bank = 2'd2;
    #1 check(req_ready == 1'b1, "R12", "undefined code accepted", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    check({sd_ras_n, sd_cas_n, sd_we_n} == E_NOP, "R12", "undefined code drives NOP",
          {sd_ras_n, sd_cas_n, sd_we_n}, E_NOP);

    req_cmd = 3'd0; req_bank = 2'd0;
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0 && unexp == 0, "R13", "no command without valid",
          unexp, 0);
    check(t_mrs == m, "R4", "mode load cycle", t_mrs, m);

    while (cyc != m + T_REFI - 1) @(negedge clk);
    expect_cmd(E_PRE, 2'd0, AW'(1 << 10), '0, m + T_REFI + 1, "R11");
    expect_cmd(E_REF, 2'd0, '0, '0, m + T_REFI + 1 + T_RP, "R11");
    send(3'd0, 2'd0, 12'h777, 1'b0, "R11", k);
    check(k == m + T_REFI + 1 + T_RP + T_RFC, "R11", "request held behind refresh",
          k, m + T_REFI + 1 + T_RP + T_RFC);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11", "all expected commands seen", exp_q.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule